// File: doc/BRIEF.md
# Programmable-Order CIC Decimator

A multiplier-free low-pass decimator built from a cascade of integrators running at the input rate, a decimation register, and a cascade of comb differentiators running at the decimated rate. A 16-bit two's complement sample enters on every clock. A rounded 16-bit sample leaves each time the external divider asserts its decimated-rate enable. The enable comes from a separate clock divider that sets the decimation factor (1 to 1024).

The filter order (0 to 5 active stages) can be changed at run time. Each stage has its own feedback enable. Every stage keeps a fixed number of the most significant bits of a 66-bit internal frame. The input is sign-extended and shifted so that its LSB lands at a programmable growth position. This lets the user trade headroom against precision for the chosen order and decimation. The comb result is rounded symmetrically (half away from zero) and saturated to 16 bits.

A bypass control passes the input through unfiltered, with no dependence on the order, growth or divider settings.

Top module: `cic_decim`

## Requirements
- R1: An active-low asynchronous reset clears the input, integrator, decimation, comb and output registers; after reset `out_data` is 0 and `out_valid` is 0.
- R2: The input is sign-extended into a 66-bit frame with its LSB at bit `cfg_growth`. The value presented to the rounder is frame bits 65:47, read as 16 integer bits and 3 fraction bits. With no active stages and the enable high every cycle, growth 50 gives out = in, and growth 49 gives out = round(in/2).
- R3: Stage k (1..5) is active when k <= `cfg_stages`. Value 0 makes every stage pass data unaltered; values 6 and 7 behave as 5. An inactive integrator has zero feedback, and an inactive comb subtracts zero.
- R4: The integrator registers keep the top 63, 53, 43, 35 and 26 frame bits. The comb outputs keep the top 22, 21, 20, 19 and 19 bits after a 26-bit decimation register. All arithmetic wraps modulo the frame.
- R5: On each clock edge where the enable is high, the decimation register, comb registers and output register load. `out_valid` is high for exactly the cycle after each such edge, and `out_data` holds between loads.
- R6: Rounding is based on the 3 fraction bits f. A non-negative value adds one when f >= 4. A negative value adds one when f > 4. Otherwise the value is truncated. The result is rounded half away from zero.
- R7: A positive value whose rounding would pass 32767 yields 32767 and never wraps to a negative code.
- R8: With `cfg_bypass` high, all stages are inactive, the comb registers are held at zero, growth is taken as 50 and the enable is forced high. `out_data` then equals the input presented 8 clock edges earlier, whatever `cfg_stages`, `cfg_growth` and `dec_en` are.
- R9: With N active stages, decimation R (a power of two), and growth 50 - N*log2(R), a constant input settles to an output equal to that input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input-rate clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_data | input | 16 | Input sample, two's complement fraction |
| dec_en | input | 1 | Decimated-rate enable from the external divider |
| cfg_stages | input | 3 | Number of active stages |
| cfg_growth | input | 6 | Frame bit position of the input LSB |
| cfg_bypass | input | 1 | Pass input through unfiltered |
| out_data | output | 16 | Rounded, saturated output sample |
| out_valid | output | 1 | One-cycle strobe for each new output |

## Verification
The bench drives the rounder with exact half, below-half and above-half fractions of both signs, using the growth shift with no stages active. A design that rounds toward plus infinity or truncates would return the wrong neighbouring code. A value one half step above full scale is produced through a single stage with decimation by three; a missing saturation would wrap it to -32768. Constant inputs through 3-stage and 5-stage configurations, and through an out-of-range stage count, must return the input exactly. A wrong stage decode or wrong truncation points would scale or corrupt it. Bypass is checked for exact 8-edge latency with the divider enable held low, and the number of valid strobes is counted against the divider rate.

// File: rtl/cic_decim.sv
module cic_decim #(
  parameter int IN_W  = 16,
  parameter int FW    = 66,
  parameter int OUT_W = 16,
  parameter int FR_W  = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IN_W-1:0]  in_data,
  input  logic             dec_en,
  input  logic [2:0]       cfg_stages,
  input  logic [5:0]       cfg_growth,
  input  logic             cfg_bypass,
  output logic [OUT_W-1:0] out_data,
  output logic             out_valid
);
  localparam int NS   = 5;
  localparam int RW   = OUT_W + FR_W;
  localparam int BYPG = 50;

  function automatic int int_w(int k);
    case (k)
      0: return 66;
      1: return 63;
      2: return 53;
      3: return 43;
      4: return 35;
      default: return 26;
    endcase
  endfunction

  function automatic int cmb_w(int k);
    case (k)
      0: return 26;
      1: return 22;
      2: return 21;
      3: return 20;
      default: return 19;
    endcase
  endfunction

  logic [IN_W-1:0] in_q;
  logic [FW-1:0]   ext, shifted;
  logic [5:0]      gsh;
  logic            ce;
  logic [NS:1]     act;
  logic [FW-1:0]   int_in [1:NS];
  logic [FW-1:0]   int_q  [1:NS];
  logic [FW-1:0]   dec_q;
  logic [FW-1:0]   cv     [0:NS];
  logic [FW-1:0]   cmb_q  [1:NS];
  logic [RW-1:0]   c19;
  logic [OUT_W-1:0] ipart, rnd;
  logic [FR_W-1:0] frac;
  logic            up, sat;

  assign ce      = dec_en | cfg_bypass;
  assign gsh     = cfg_bypass ? 6'(BYPG) : cfg_growth;
  assign ext     = {{(FW-IN_W){in_q[IN_W-1]}}, in_q};
  assign shifted = ext << gsh;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) in_q <= '0;
    else        in_q <= in_data;

  for (genvar k = 1; k <= NS; k++) begin : g_int
    localparam logic [FW-1:0] IM = {FW{1'b1}} << (FW - int_w(k));
    assign act[k] = !cfg_bypass && (cfg_stages >= 3'(k));
    if (k == 1) begin : g_first
      assign int_in[k] = shifted;
    end else begin : g_next
      assign int_in[k] = int_q[k-1];
    end
    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) int_q[k] <= '0;
      else        int_q[k] <= (int_in[k] + (act[k] ? int_q[k] : '0)) & IM;
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)  dec_q <= '0;
    else if (ce) dec_q <= int_q[NS];

  assign cv[0] = dec_q;

  for (genvar k = 1; k <= NS; k++) begin : g_cmb
    localparam logic [FW-1:0] CM = {FW{1'b1}} << (FW - cmb_w(k));
    assign cv[k] = (cv[k-1] - (act[k] ? cmb_q[k] : '0)) & CM;
    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n)          cmb_q[k] <= '0;
      else if (cfg_bypass) cmb_q[k] <= '0;
      else if (ce)         cmb_q[k] <= cv[k-1];

    p_comb_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_bypass |=> cmb_q[k] == '0);
  end

  assign c19   = cv[NS][FW-1 -: RW];
  assign ipart = c19[RW-1:FR_W];
  assign frac  = c19[FR_W-1:0];
  assign up    = c19[RW-1] ? (frac > 3'd4) : (frac >= 3'd4);
  assign sat   = up && (ipart == {1'b0, {(OUT_W-1){1'b1}}});
  assign rnd   = sat ? ipart : OUT_W'(ipart + OUT_W'(up));

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      out_data  <= '0;
      out_valid <= 1'b0;
    end else begin
      out_valid <= ce;
      if (ce) out_data <= rnd;
    end

  p_valid_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ce |=> out_valid);
  p_valid_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !ce |=> !out_valid);
  p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !ce |=> $stable(out_data));
  p_no_wrap_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ce && !c19[RW-1]) |=> !out_data[OUT_W-1]);
  p_dec_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !ce |=> $stable(dec_q));
endmodule

// File: tb/cic_decim_test.sv
module cic_decim_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] in_data = '0;
  logic        dec_en = 1'b0;
  logic [2:0]  cfg_stages = '0;
  logic [5:0]  cfg_growth = 6'd50;
  logic        cfg_bypass = 1'b0;
  logic [15:0] out_data;
  logic        out_valid;

  int n_chk = 0;
  int n_bad = 0;
  int dv = 1;
  int ph = 0;
  bit done = 0;

  cic_decim uut (
    .clk(clk), .rst_n(rst_n), .in_data(in_data), .dec_en(dec_en),
    .cfg_stages(cfg_stages), .cfg_growth(cfg_growth), .cfg_bypass(cfg_bypass),
    .out_data(out_data), .out_valid(out_valid)
  );

  always #2.5 clk = ~clk;

  task automatic chk(string req, int got, int exp);
    n_chk++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d", req, got, exp);
    end
  endtask

  task automatic cyc(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      dec_en = (dv > 0) && (ph == dv - 1);
      ph = (dv > 0) ? (ph + 1) % dv : 0;
    end
  endtask

  task automatic restart(int stg, int g, bit byp, int div);
    @(negedge clk);
    rst_n = 1'b0;
    in_data = '0;
    cfg_stages = 3'(stg);
    cfg_growth = 6'(g);
    cfg_bypass = byp;
    dv = div;
    ph = 0;
    dec_en = 1'b0;
    cyc(2);
    rst_n = 1'b1;
    cyc(2);
  endtask

  task automatic t_reset;
    restart(5, 40, 0, 4);
    rst_n = 1'b0;
    cyc(1);
    chk("R1 out_data", int'($signed(out_data)), 0);
    chk("R1 out_valid", int'(out_valid), 0);
    rst_n = 1'b1;
  endtask

  task automatic t_bypass;
    restart(5, 12, 1, 0);
    in_data = 16'sd32767;
    cyc(12);
    chk("R8 bypass max", int'($signed(out_data)), 32767);
    in_data = -16'sd32768;
    cyc(12);
    chk("R8 bypass min", int'($signed(out_data)), -32768);
    in_data = 16'sd1234;
    cyc(7);
    chk("R8 latency old", int'($signed(out_data)), -32768);
    cyc(1);
    chk("R8 latency new", int'($signed(out_data)), 1234);
  endtask

  task automatic t_growth;
    int xs[5] = '{5, -5, 7, -7, 6};
    int es[5] = '{3, -3, 4, -4, 3};
    restart(0, 49, 0, 1);
    for (int i = 0; i < 5; i++) begin
      in_data = 16'(xs[i]);
      cyc(12);
      chk("R2 growth 49", int'($signed(out_data)), es[i]);
    end
    restart(0, 50, 0, 1);
    in_data = -16'sd300;
    cyc(12);
    chk("R3 zero stages", int'($signed(out_data)), -300);
  endtask

  task automatic t_round;
    int xs[7] = '{20, 19, -20, -19, -12, -16, -18};
    int es[7] = '{3, 2, -3, -2, -2, -2, -2};
    restart(0, 47, 0, 1);
    for (int i = 0; i < 7; i++) begin
      in_data = 16'(xs[i]);
      cyc(12);
      chk("R6 symmetric round", int'($signed(out_data)), es[i]);
    end
  endtask

  task automatic t_sat;
    restart(1, 49, 0, 3);
    in_data = 16'sd21845;
    cyc(60);
    chk("R7 saturate", int'($signed(out_data)), 32767);
    restart(1, 49, 0, 3);
    in_data = 16'sd21844;
    cyc(60);
    chk("R7 below limit", int'($signed(out_data)), 32766);
  endtask

  task automatic t_dc;
    restart(5, 40, 0, 4);
    in_data = 16'sd4608;
    cyc(150);
    chk("R9 R4 order5 dc", int'($signed(out_data)), 4608);
    restart(5, 40, 0, 4);
    in_data = -16'sd2560;
    cyc(150);
    chk("R9 R4 order5 negative dc", int'($signed(out_data)), -2560);
    restart(3, 41, 0, 8);
    in_data = 16'sd2048;
    cyc(200);
    chk("R9 R3 order3 dc", int'($signed(out_data)), 2048);
    restart(7, 40, 0, 4);
    in_data = 16'sd4608;
    cyc(150);
    chk("R3 stages 7 as 5", int'($signed(out_data)), 4608);
  endtask

  task automatic t_valid;
    int cnt;
    restart(2, 44, 0, 4);
    cyc(8);
    cnt = 0;
    for (int i = 0; i < 40; i++) begin
      cyc(1);
      cnt += int'(out_valid);
    end
    chk("R5 strobes per 40 at R=4", cnt, 10);
    restart(2, 42, 0, 16);
    cyc(20);
    cnt = 0;
    for (int i = 0; i < 64; i++) begin
      cyc(1);
      cnt += int'(out_valid);
    end
    chk("R5 strobes per 64 at R=16", cnt, 4);
  endtask

  task automatic t_bypass_after;
    restart(5, 40, 0, 4);
    in_data = 16'sd4608;
    cyc(100);
    cfg_bypass = 1'b1;
    dv = 0;
    in_data = -16'sd77;
    cyc(12);
    chk("R8 R4 bypass after filtering", int'($signed(out_data)), -77);
  endtask

  initial begin
    #(5.0 * 200000);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: got 0 expected 1");
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_bypass();
    t_growth();
    t_round();
    t_sat();
    t_dc();
    t_valid();
    t_bypass_after();
    done = 1;
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule